// File: doc/BRIEF.md
# Compressed Halfword Expander (byte/halfword memory, extend and multiply group)

This block turns one 16-bit compressed instruction from the code-size-reduction group into the equivalent full 32-bit instruction. The group covers byte and halfword loads and stores, the unary zero/sign-extend and bitwise-invert operations, and a compressed multiply. All of these address only the eight registers x8 to x15 through 3-bit fields. The block also reports when a halfword falls into the group's own encoding space but uses a reserved code. Halfwords outside that space are left to other decoders: both flags stay low for them.

A mode input selects the 64-bit register-width behaviour. It makes the 32-bit-to-64-bit zero-extend legal, and it moves the halfword zero-extend to the word-width opcode. The expansion is combinational. A parameter `REG_OUT` (default 1) adds one register stage on all three outputs, with an asynchronous active-low reset.

Top module: `cxp_expander`

## Requirements
- R1: With `REG_OUT`=1, the outputs `wordOut`, `validOut` and `illegalOut` are all zero while reset is asserted and until the first clock edge after its release.
- R2: A halfword with bits[1:0]=00, bits[15:13]=100 and bits[12:10]=000 expands to a byte load unsigned (funct3 100, opcode 0000011). The destination register is x(8+bits[4:2]) and the base is x(8+bits[9:7]). The offset is bit5*2+bit6, zero-extended into the 12-bit immediate.
- R3: The same header with bits[12:10]=001 expands to a halfword load with offset bit5*2. When bit6=1 the load is signed (funct3 001); otherwise it is unsigned (funct3 101). Opcode is 0000011.
- R4: Bits[12:10]=010 expands to a byte store (funct3 000, offset bit5*2+bit6). Bits[12:10]=011 with bit6=0 expands to a halfword store (funct3 001, offset bit5*2). The data register is x(8+bits[4:2]), the base is x(8+bits[9:7]) and the opcode is 0100011. Bits[12:10]=011 with bit6=1 is reserved: it sets `illegalOut`.
- R5: In the load/store header, bits[12:10] from 100 to 111 are reserved and set `illegalOut`.
- R6: With bits[1:0]=01, bits[15:10]=100111 and bits[6:5]=11, register r=x(8+bits[9:7]) is both source and destination. Code bits[4:2]=000 gives an AND-immediate with 0x0FF. Code 001 gives sign-extend-byte (funct12 0x604, funct3 001, opcode 0010011). Code 011 gives sign-extend-halfword (funct12 0x605, funct3 001, opcode 0010011).
- R7: Unary code 010 (halfword zero-extend) expands to funct7 0000100, rs2 x0, funct3 100. The opcode is 0110011 in 32-bit mode and 0111011 in 64-bit mode.
- R8: Unary code 100 (word zero-extend) in 64-bit mode expands to an add-unsigned-word of r and x0 (funct7 0000100, funct3 000, opcode 0111011). In 32-bit mode it sets `illegalOut`.
- R9: Unary code 101 (invert) expands to an XOR-immediate of r with -1 (immediate 0xFFF, funct3 100, opcode 0010011).
- R10: Bits[6:5]=10 in the unary header expands to a multiply: destination and first source x(8+bits[9:7]), second source x(8+bits[4:2]), funct7 0000001, funct3 000, opcode 0110011.
- R11: Unary codes 110 and 111 are reserved and set `illegalOut`.
- R12: Any halfword outside the two headers keeps both flags low. This includes the unary header with bits[6:5] equal to 00 or 01. Whenever `validOut` is low, `wordOut` is zero.
- R13: `validOut` and `illegalOut` are never high together. Results appear `REG_OUT` clock cycles after the halfword is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rstN | input | 1 | Asynchronous active-low reset |
| halfIn | input | 16 | Compressed halfword to expand |
| wide64 | input | 1 | 1 selects the 64-bit register-width mode |
| wordOut | output | 32 | Expanded instruction, zero when not valid |
| validOut | output | 1 | Halfword is a legal member of the group |
| illegalOut | output | 1 | Halfword uses a reserved code inside the group |

## Verification
With the default output stage, each result is due on the rising edge that follows the halfword presentation. Without that stage, it is due in the same cycle. The bench changes `halfIn` and `wide64` on the falling edge and compares just after the next rising edge. At that point both latencies show the result of the halfword driven half a cycle earlier, so one expected item is queued per driven halfword and consumed one per edge. Every one of the 65,536 halfwords is checked in both modes.

// File: rtl/cxp_pkg.sv
package cxp_pkg;

  localparam int HALF_W = 16;
  localparam int WORD_W = 32;
  localparam int CREG_W = 3;
  localparam int XREG_W = 5;

  typedef enum logic [3:0] {
    OP_NONE, OP_LDBU, OP_LDHU, OP_LDHS, OP_STB, OP_STH,
    OP_ZXB, OP_SXB, OP_ZXH, OP_SXH, OP_ZXW, OP_INV, OP_MULT
  } cxpOp_e;

  // strobes from control to datapath
  typedef struct packed {
    cxpOp_e op;
    logic   inSpace;
    logic   rsvd;
    logic   wideOpc;
  } cxpStrobe_t;

  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;
  localparam logic [6:0] OPC_IMM   = 7'b0010011;
  localparam logic [6:0] OPC_REG   = 7'b0110011;
  localparam logic [6:0] OPC_REGW  = 7'b0111011;

  function automatic logic [XREG_W-1:0] fullReg(input logic [CREG_W-1:0] c);
    return {2'b01, c};
  endfunction

  function automatic logic [WORD_W-1:0] encImm(input logic [11:0] imm,
      input logic [XREG_W-1:0] src, input logic [2:0] f3,
      input logic [XREG_W-1:0] dst, input logic [6:0] opc);
    return {imm, src, f3, dst, opc};
  endfunction

  function automatic logic [WORD_W-1:0] encSt(input logic [11:0] imm,
      input logic [XREG_W-1:0] data, input logic [XREG_W-1:0] base,
      input logic [2:0] f3, input logic [6:0] opc);
    return {imm[11:5], data, base, f3, imm[4:0], opc};
  endfunction

  function automatic logic [WORD_W-1:0] encReg(input logic [6:0] f7,
      input logic [XREG_W-1:0] s2, input logic [XREG_W-1:0] s1,
      input logic [2:0] f3, input logic [XREG_W-1:0] dst, input logic [6:0] opc);
    return {f7, s2, s1, f3, dst, opc};
  endfunction

endpackage

// File: rtl/cxp_decode.sv
module cxp_decode
  import cxp_pkg::*;
(
  input  logic [5:0] opHi,   // halfword bits 15:10
  input  logic [4:0] subSel, // halfword bits 6:2
  input  logic [1:0] quad,   // halfword bits 1:0
  input  logic       wide64,
  output cxpStrobe_t strobe
);

  logic memHdr;
  logic aluHdr;

  assign memHdr = (quad == 2'b00) && (opHi[5:3] == 3'b100);
  assign aluHdr = (quad == 2'b01) && (opHi == 6'b100111) && subSel[4];

  always_comb begin
    strobe = '{op: OP_NONE, inSpace: 1'b0, rsvd: 1'b0, wideOpc: 1'b0};
    if (memHdr) begin
      strobe.inSpace = 1'b1;
      unique case (opHi[2:0])
        3'b000:  strobe.op = OP_LDBU;
        3'b001:  strobe.op = subSel[4] ? OP_LDHS : OP_LDHU;
        3'b010:  strobe.op = OP_STB;
        3'b011: begin
          if (subSel[4]) strobe.rsvd = 1'b1;
          else           strobe.op   = OP_STH;
        end
        default: strobe.rsvd = 1'b1;
      endcase
    end else if (aluHdr) begin
      strobe.inSpace = 1'b1;
      if (!subSel[3]) begin
        strobe.op = OP_MULT;
      end else begin
        unique case (subSel[2:0])
          3'b000: strobe.op = OP_ZXB;
          3'b001: strobe.op = OP_SXB;
          3'b010: begin
            strobe.op      = OP_ZXH;
            strobe.wideOpc = wide64;
          end
          3'b011: strobe.op = OP_SXH;
          3'b100: begin
            if (wide64) strobe.op   = OP_ZXW;
            else        strobe.rsvd = 1'b1;
          end
          3'b101: strobe.op = OP_INV;
          default: strobe.rsvd = 1'b1;
        endcase
      end
    end
  end

endmodule

// File: rtl/cxp_build.sv
module cxp_build
  import cxp_pkg::*;
(
  input  logic [7:0]        fieldIn, // halfword bits 9:2
  input  cxpStrobe_t        strobe,
  output logic [WORD_W-1:0] wordOut,
  output logic              validOut,
  output logic              illegalOut
);

  logic [XREG_W-1:0] regA;
  logic [XREG_W-1:0] regB;
  logic              offB1;
  logic              offB0;
  logic [11:0]       byteOff;
  logic [11:0]       halfOff;
  logic [WORD_W-1:0] built;

  assign regA    = fullReg(fieldIn[7:5]);
  assign regB    = fullReg(fieldIn[2:0]);
  assign offB0   = fieldIn[4];
  assign offB1   = fieldIn[3];
  assign byteOff = {10'd0, offB1, offB0};
  assign halfOff = {10'd0, offB1, 1'b0};

  always_comb begin
    built = '0;
    unique case (strobe.op)
      OP_LDBU: built = encImm(byteOff, regA, 3'b100, regB, OPC_LOAD);
      OP_LDHU: built = encImm(halfOff, regA, 3'b101, regB, OPC_LOAD);
      OP_LDHS: built = encImm(halfOff, regA, 3'b001, regB, OPC_LOAD);
      OP_STB:  built = encSt(byteOff, regB, regA, 3'b000, OPC_STORE);
      OP_STH:  built = encSt(halfOff, regB, regA, 3'b001, OPC_STORE);
      OP_ZXB:  built = encImm(12'h0FF, regA, 3'b111, regA, OPC_IMM);
      OP_SXB:  built = encImm(12'h604, regA, 3'b001, regA, OPC_IMM);
      OP_SXH:  built = encImm(12'h605, regA, 3'b001, regA, OPC_IMM);
      OP_ZXH:  built = encReg(7'b0000100, 5'd0, regA, 3'b100, regA,
                              strobe.wideOpc ? OPC_REGW : OPC_REG);
      OP_ZXW:  built = encReg(7'b0000100, 5'd0, regA, 3'b000, regA, OPC_REGW);
      OP_INV:  built = encImm(12'hFFF, regA, 3'b100, regA, OPC_IMM);
      OP_MULT: built = encReg(7'b0000001, regB, regA, 3'b000, regA, OPC_REG);
      default: built = '0;
    endcase
  end

  assign validOut   = strobe.inSpace && !strobe.rsvd;
  assign illegalOut = strobe.inSpace && strobe.rsvd;
  assign wordOut    = validOut ? built : '0;

endmodule

// File: rtl/cxp_expander.sv
module cxp_expander
  import cxp_pkg::*;
#(
  parameter int REG_OUT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [HALF_W-1:0] halfIn,
  input  logic              wide64,
  output logic [WORD_W-1:0] wordOut,
  output logic              validOut,
  output logic              illegalOut
);

  cxpStrobe_t        strobe;
  logic [WORD_W-1:0] combWord;
  logic              combValid;
  logic              combIllegal;

  cxp_decode uDecode (
    .opHi   (halfIn[15:10]),
    .subSel (halfIn[6:2]),
    .quad   (halfIn[1:0]),
    .wide64 (wide64),
    .strobe (strobe)
  );

  cxp_build uBuild (
    .fieldIn    (halfIn[9:2]),
    .strobe     (strobe),
    .wordOut    (combWord),
    .validOut   (combValid),
    .illegalOut (combIllegal)
  );

  generate
    if (REG_OUT != 0) begin : gRegOut
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          wordOut    <= '0;
          validOut   <= 1'b0;
          illegalOut <= 1'b0;
        end else begin
          wordOut    <= combWord;
          validOut   <= combValid;
          illegalOut <= combIllegal;
        end
      end
    end else begin : gCombOut
      assign wordOut    = combWord;
      assign validOut   = combValid;
      assign illegalOut = combIllegal;
    end
  endgenerate

endmodule

// File: rtl/cxp_expander_chk.sv
module cxp_expander_chk #(
  parameter int REG_OUT = 1
) (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] halfIn,
  input logic        wide64,
  input logic [31:0] wordOut,
  input logic        validOut,
  input logic        illegalOut
);

  logic [15:0] prevHalf;
  logic        prevWide;
  logic        prevOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevHalf <= '0;
      prevWide <= 1'b0;
      prevOk   <= 1'b0;
    end else begin
      prevHalf <= halfIn;
      prevWide <= wide64;
      prevOk   <= 1'b1;
    end
  end

  logic [15:0] srcHalf;
  logic        srcWide;
  logic        srcOk;
  logic        srcUnary;

  assign srcHalf  = (REG_OUT != 0) ? prevHalf : halfIn;
  assign srcWide  = (REG_OUT != 0) ? prevWide : wide64;
  assign srcOk    = (REG_OUT != 0) ? prevOk : 1'b1;
  assign srcUnary = (srcHalf[1:0] == 2'b01) && (srcHalf[15:10] == 6'b100111)
                    && (srcHalf[6:5] == 2'b11);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !srcOk |-> (!validOut && !illegalOut && wordOut == '0)); // R1

  AST_FLAGS_DISJOINT: assert property (@(posedge clk) disable iff (!rstN)
    !(validOut && illegalOut)); // R13

  AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !validOut |-> wordOut == '0); // R12

  AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (srcOk && srcHalf[1]) |-> (!validOut && !illegalOut)); // R12

  AST_MEM_RSVD: assert property (@(posedge clk) disable iff (!rstN)
    (srcOk && srcHalf[1:0] == 2'b00 && srcHalf[15:12] == 4'b1001) |-> illegalOut); // R5

  AST_ZXW_NARROW: assert property (@(posedge clk) disable iff (!rstN)
    (srcOk && !srcWide && srcUnary && srcHalf[4:2] == 3'b100) |-> (illegalOut && !validOut)); // R8

  AST_UNARY_RSVD: assert property (@(posedge clk) disable iff (!rstN)
    (srcOk && srcUnary && srcHalf[4:3] == 2'b11) |-> illegalOut); // R11

  AST_ALU_DEST: assert property (@(posedge clk) disable iff (!rstN)
    (srcOk && validOut && srcHalf[1:0] == 2'b01) |-> wordOut[11:7] == {2'b01, srcHalf[9:7]}); // R10

endmodule

bind cxp_expander cxp_expander_chk #(.REG_OUT(REG_OUT)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .halfIn     (halfIn),
  .wide64     (wide64),
  .wordOut    (wordOut),
  .validOut   (validOut),
  .illegalOut (illegalOut)
);

// File: tb/tb_cxp_expander.sv
module tb_cxp_expander;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] halfIn = 16'h9C41;
  logic        wide64 = 1'b0;
  logic [31:0] wordOut;
  logic        validOut;
  logic        illegalOut;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit driveDone = 1'b0;

  typedef struct {
    logic [31:0] w;
    logic        v;
    logic        il;
    string       tag;
    logic [15:0] h;
    logic        m;
  } expItem_t;

  expItem_t pending[$];

  cxp_expander #(.REG_OUT(1)) dut (
    .clk(clk), .rstN(rstN), .halfIn(halfIn), .wide64(wide64),
    .wordOut(wordOut), .validOut(validOut), .illegalOut(illegalOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model written from the requirement text
  function automatic expItem_t refModel(input logic [15:0] h, input logic m);
    expItem_t e;
    logic [4:0] ra;
    logic [4:0] rb;
    ra = {2'b01, h[9:7]};
    rb = {2'b01, h[4:2]};
    e = '{w: 32'd0, v: 1'b0, il: 1'b0, tag: "R12", h: h, m: m};
    if (h[1:0] == 2'b00 && h[15:13] == 3'b100) begin
      if (h[12]) begin
        e.il = 1'b1; e.tag = "R5";
      end else if (h[11:10] == 2'b00) begin
        e.v = 1'b1; e.tag = "R2";
        e.w = {20'd0, 7'd0, 5'd0, 7'd0} | ({30'd0, h[5], h[6]} << 20)
              | {12'd0, ra, 3'b100, rb, 7'b0000011};
      end else if (h[11:10] == 2'b01) begin
        e.v = 1'b1; e.tag = "R3";
        e.w = ({30'd0, h[5], 1'b0} << 20)
              | {12'd0, ra, (h[6] ? 3'b001 : 3'b101), rb, 7'b0000011};
      end else if (h[11:10] == 2'b10) begin
        e.v = 1'b1; e.tag = "R4";
        e.w = {7'd0, rb, ra, 3'b000, 3'd0, h[5], h[6], 7'b0100011};
      end else if (h[6]) begin
        e.il = 1'b1; e.tag = "R4";
      end else begin
        e.v = 1'b1; e.tag = "R4";
        e.w = {7'd0, rb, ra, 3'b001, 3'd0, h[5], 1'b0, 7'b0100011};
      end
    end else if (h[1:0] == 2'b01 && h[15:10] == 6'b100111 && h[6]) begin
      if (!h[5]) begin
        e.v = 1'b1; e.tag = "R10";
        e.w = {7'b0000001, rb, ra, 3'b000, ra, 7'b0110011};
      end else begin
        e.v = 1'b1;
        case (h[4:2])
          3'd0: begin e.tag = "R6"; e.w = {12'h0FF, ra, 3'b111, ra, 7'b0010011}; end
          3'd1: begin e.tag = "R6"; e.w = {12'h604, ra, 3'b001, ra, 7'b0010011}; end
          3'd3: begin e.tag = "R6"; e.w = {12'h605, ra, 3'b001, ra, 7'b0010011}; end
          3'd2: begin
            e.tag = "R7";
            e.w = {7'b0000100, 5'd0, ra, 3'b100, ra, (m ? 7'b0111011 : 7'b0110011)};
          end
          3'd4: begin
            e.tag = "R8";
            if (m) e.w = {7'b0000100, 5'd0, ra, 3'b000, ra, 7'b0111011};
            else begin e.v = 1'b0; e.il = 1'b1; end
          end
          3'd5: begin e.tag = "R9"; e.w = {12'hFFF, ra, 3'b100, ra, 7'b0010011}; end
          default: begin e.tag = "R11"; e.v = 1'b0; e.il = 1'b1; end
        endcase
      end
    end
    return e;
  endfunction

  task automatic checkReset(input string what);
    checks++;
    if (wordOut !== 32'd0 || validOut !== 1'b0 || illegalOut !== 1'b0) begin
      fails++;
      $display("FAIL R1 %s: got word=%h v=%b il=%b expected word=00000000 v=0 il=0",
               what, wordOut, validOut, illegalOut);
    end
  endtask

  task automatic pushHalf(input logic [15:0] h, input logic m);
    @(negedge clk);
    halfIn = h;
    wide64 = m;
    pending.push_back(refModel(h, m));
  endtask

  // driver
  initial begin
    repeat (3) @(negedge clk);
    checkReset("during reset");
    @(negedge clk);
    rstN = 1'b1;
    checkReset("after release, before edge");
    for (int mode = 0; mode < 2; mode++) begin
      for (int h = 0; h < 65536; h++) begin
        pushHalf(h[15:0], mode[0]);
      end
    end
    @(negedge clk);
    driveDone = 1'b1;
  end

  // monitor: one result per rising edge, read just after it
  initial begin
    expItem_t e;
    forever begin
      @(posedge clk);
      #1;
      if (pending.size() > 0) begin
        e = pending.pop_front();
        checks++;
        if (wordOut !== e.w || validOut !== e.v || illegalOut !== e.il) begin
          fails++;
          $display("FAIL %s half=%h wide=%b: got word=%h v=%b il=%b expected word=%h v=%b il=%b (R13)",
                   e.tag, e.h, e.m, wordOut, validOut, illegalOut, e.w, e.v, e.il);
        end
      end
    end
  end

  // watchdog and finish
  initial begin
    while (!(driveDone && pending.size() == 0) && cycles < WATCHDOG) begin
      @(posedge clk);
      cycles++;
    end
    if (cycles >= WATCHDOG) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d cycles expected completion below %0d", cycles, WATCHDOG);
    end
    #2;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule